// File: doc/BRIEF.md
# Shared-Counter Time Base and Watchdog

This block produces two timing services from one counter chain: a periodic square-wave tick for a host, and a watchdog flag that trips when the host stops servicing it. Both run from a 32 kHz-equivalent rate. That rate comes either straight from the oscillator tick input or, when the oscillator runs at 256 kHz, through a divide-by-8 prescaler. A 3-bit rate code then divides the rate by a power of two, from 1 to 128, before it reaches an 8-stage counter. In watchdog mode, a further 2-stage counter follows the 8-stage counter.

Commands arrive as single-cycle decoded pulses. They start or stop the tick mode and the watchdog mode, clear the counters, load the rate code, and enable or disable an active-low interrupt pin. The pin is modelled as an output enable plus a driven value. The value follows the tick wave in tick mode and the inverted watchdog flag otherwise.

A three-state machine selects what the shared counter does:
- **IDLE**: the counter holds its value.
- **TICK**: the counter runs and its top bit is the tick output.
- **GUARD**: the counter runs and its wraps feed the watchdog stage.

The transitions are:
- *start_tick*: IDLE or GUARD to TICK.
- *start_guard*: IDLE or TICK to GUARD.
- *stop_tick*: TICK to IDLE.
- *stop_all*: any state to IDLE.

When the system-enable input is low, all counting freezes.

Top module: `tbwd_top`

## Requirements
- R1: After reset the mode is IDLE, all counters and the watchdog flag are zero, the rate code is 3'b111, the interrupt is disabled (irq_oe=0) and irq_val=1.
- R2: With fast_src=1, a base tick occurs once per 8 qualifying src_tick cycles. With fast_src=0, every qualifying src_tick is a base tick.
- R3: Rate code c (loaded with cmd_freq_wr, effective the next cycle) advances the 8-stage counter once every 2^(7-c) base ticks. In TICK mode, tb_out is bit 7 of that counter, giving a square wave of 256 counter advances per period.
- R4: State changes have this priority: stop_all (cmd_wdt_dis) > stop_tick (cmd_tmr_dis, honoured only in TICK) > start_guard (cmd_wdt_en) > start_tick (cmd_tmr_en). cmd_tmr_dis in GUARD has no effect.
- R5: tb_out is 0 outside TICK. In IDLE the counter holds its value, and it resumes from that value on re-entry to a running mode.
- R6: cmd_clr_tmr zeroes the 8-stage counter. cmd_clr_wdt zeroes the 8-stage counter, the watchdog stage and the watchdog flag. Both take priority over counting in the same cycle.
- R7: In GUARD, wdt_flag sets on the 1024th counter advance after a cmd_clr_wdt. It then stays set until cmd_clr_wdt or cmd_irq_dis, and a clear wins over a set in the same cycle.
- R8: While sys_on=0, the prescaler, rate divider, counter and watchdog stage all hold. Commands are still accepted.
- R9: irq_oe equals the interrupt-enable bit: cmd_irq_en sets it, cmd_irq_dis clears it, and disable wins if both arrive together. irq_val is the tick wave in TICK and the inverted wdt_flag in IDLE and GUARD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_on | input | 1 | System enable; low freezes all counting |
| src_tick | input | 1 | One pulse per oscillator period |
| fast_src | input | 1 | 1: oscillator is 256 kHz, apply the divide-by-8 prescaler |
| cmd_tmr_en | input | 1 | start_tick pulse |
| cmd_tmr_dis | input | 1 | stop_tick pulse |
| cmd_wdt_en | input | 1 | start_guard pulse |
| cmd_wdt_dis | input | 1 | stop_all pulse |
| cmd_clr_tmr | input | 1 | Clear the 8-stage counter |
| cmd_clr_wdt | input | 1 | Clear the counter, the watchdog stage and the flag |
| cmd_irq_en | input | 1 | Enable the interrupt pin |
| cmd_irq_dis | input | 1 | Disable the interrupt pin and clear the flag |
| cmd_freq_wr | input | 1 | Load freq_sel as the rate code |
| freq_sel | input | 3 | Rate code; 0 is slowest, 7 is fastest |
| tb_out | output | 1 | Time-base square wave |
| wdt_flag | output | 1 | Watchdog time-out flag |
| irq_oe | output | 1 | Interrupt pin drive enable |
| irq_val | output | 1 | Interrupt pin value when driven |

## Verification
The hardest state to reach is a tripped watchdog that meets a suppressed or competing command. Examples are a stop_tick arriving in GUARD, an interrupt disable arriving while the flag is set, and a power-down in the middle of a count. Reaching any of these first needs 1024 counter advances in GUARD. The stimulus therefore selects the fastest rate code with the prescaler bypassed, so that one advance occurs per clock. It then brings the count to exactly one advance before the trip, steps across the boundary, and issues the competing commands.

A long randomised phase follows. It uses gapped source ticks, toggles the prescaler, issues mixed command pulses and changes the rate code. A behavioural model is compared against the outputs on every clock throughout.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_TICK  = 2'd1,
        MODE_GUARD = 2'd2
    } tbwd_mode_e;

endpackage

// File: rtl/tbwd_clkdiv.sv
module tbwd_clkdiv #(
    parameter int PRE_DIV = 8,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_en,
    input  logic             fast_src,
    input  logic [SEL_W-1:0] freq_code,
    output logic             step
);
    localparam int DIV_W = (1 << SEL_W) - 1;
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;
    logic [SEL_W-1:0] shift;
    logic             base_tick;

    // prescaler: only advances when the fast source is selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (src_en && fast_src) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    assign base_tick = src_en && (!fast_src || (pre_q == PRE_LAST));

    // rate divider: free-running counter, tick when the low bits are all ones
    assign shift = SEL_W'(DIV_W) - freq_code;
    assign mask  = ~({DIV_W{1'b1}} << shift);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (base_tick) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign step = base_tick && ((div_q & mask) == mask);

    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && fast_src) |=> !(base_tick && fast_src)); // R2

endmodule

// File: rtl/tbwd_mode_fsm.sv
module tbwd_mode_fsm
    import tbwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_tick,
    input  logic       stop_tick,
    input  logic       start_guard,
    input  logic       stop_all,
    output tbwd_mode_e mode,
    output logic       running,
    output logic       guard
);
    tbwd_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_IDLE: begin
                if (stop_all)         state_d = MODE_IDLE;
                else if (start_guard) state_d = MODE_GUARD;
                else if (start_tick)  state_d = MODE_TICK;
            end
            MODE_TICK: begin
                if (stop_all || stop_tick) state_d = MODE_IDLE;
                else if (start_guard)      state_d = MODE_GUARD;
            end
            MODE_GUARD: begin
                if (stop_all)        state_d = MODE_IDLE;
                else if (start_tick && !start_guard) state_d = MODE_TICK;
            end
            default: state_d = MODE_IDLE;
        endcase
    end

    always_comb begin
        mode    = state_q;
        running = (state_q == MODE_TICK) || (state_q == MODE_GUARD);
        guard   = (state_q == MODE_GUARD);
    end

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_all |=> (state_q == MODE_IDLE)); // R4
    AST_GUARD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_GUARD && stop_tick && !stop_all && !start_tick) |=> (state_q == MODE_GUARD)); // R4

endmodule

// File: rtl/tbwd_chain.sv
module tbwd_chain #(
    parameter int TB_W = 8,
    parameter int WD_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            running,
    input  logic            guard,
    input  logic            clr_tmr,
    input  logic            clr_wdt,
    input  logic            irq_dis,
    output logic [TB_W-1:0] cnt,
    output logic            flag
);
    logic [TB_W-1:0] cnt_q;
    logic [WD_W-1:0] wst_q;
    logic            flag_q;
    logic            adv, wrap, trip;

    assign adv  = step && running && !clr_wdt && !clr_tmr;
    assign wrap = adv && (&cnt_q);
    assign trip = wrap && guard && (&wst_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wst_q <= '0;
        end else if (clr_wdt) begin
            cnt_q <= '0;
            wst_q <= '0;
        end else if (clr_tmr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
            if (wrap && guard) wst_q <= wst_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (clr_wdt || irq_dis) flag_q <= 1'b0;
        else if (trip)              flag_q <= 1'b1;
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wdt |=> (cnt_q == '0 && wst_q == '0 && !flag_q)); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_wdt && !irq_dis) |=> flag_q); // R7

endmodule

// File: rtl/tbwd_top.sv
module tbwd_top
    import tbwd_pkg::*;
#(
    parameter int PRE_DIV = 8,
    parameter int SEL_W   = 3,
    parameter int TB_W    = 8,
    parameter int WD_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_on,
    input  logic             src_tick,
    input  logic             fast_src,
    input  logic             cmd_tmr_en,
    input  logic             cmd_tmr_dis,
    input  logic             cmd_wdt_en,
    input  logic             cmd_wdt_dis,
    input  logic             cmd_clr_tmr,
    input  logic             cmd_clr_wdt,
    input  logic             cmd_irq_en,
    input  logic             cmd_irq_dis,
    input  logic             cmd_freq_wr,
    input  logic [SEL_W-1:0] freq_sel,
    output logic             tb_out,
    output logic             wdt_flag,
    output logic             irq_oe,
    output logic             irq_val
);
    logic [SEL_W-1:0] freq_q;
    logic             irq_en_q;
    logic             step, running, guard, flag;
    logic [TB_W-1:0]  tb_cnt;
    tbwd_mode_e       mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           freq_q <= '1;
        else if (cmd_freq_wr) freq_q <= freq_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           irq_en_q <= 1'b0;
        else if (cmd_irq_dis) irq_en_q <= 1'b0;
        else if (cmd_irq_en)  irq_en_q <= 1'b1;
    end

    tbwd_clkdiv #(.PRE_DIV(PRE_DIV), .SEL_W(SEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_tick && sys_on),
        .fast_src  (fast_src),
        .freq_code (freq_q),
        .step      (step)
    );

    tbwd_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_tick  (cmd_tmr_en),
        .stop_tick   (cmd_tmr_dis),
        .start_guard (cmd_wdt_en),
        .stop_all    (cmd_wdt_dis),
        .mode        (mode),
        .running     (running),
        .guard       (guard)
    );

    tbwd_chain #(.TB_W(TB_W), .WD_W(WD_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .running (running),
        .guard   (guard),
        .clr_tmr (cmd_clr_tmr),
        .clr_wdt (cmd_clr_wdt),
        .irq_dis (cmd_irq_dis),
        .cnt     (tb_cnt),
        .flag    (flag)
    );

    always_comb begin
        tb_out   = (mode == MODE_TICK) && tb_cnt[TB_W-1];
        wdt_flag = flag;
        irq_oe   = irq_en_q;
        irq_val  = (mode == MODE_TICK) ? tb_cnt[TB_W-1] : !flag;
    end

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_on && !cmd_clr_tmr && !cmd_clr_wdt) |=> $stable(tb_cnt)); // R8
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq_dis |=> !irq_oe); // R9

endmodule

// File: tb/sim_tbwd_top.sv
`timescale 1ns/1ps
module sim_tbwd_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_on = 1'b0, src_tick = 1'b0, fast_src = 1'b0;
    logic cmd_tmr_en = 0, cmd_tmr_dis = 0, cmd_wdt_en = 0, cmd_wdt_dis = 0;
    logic cmd_clr_tmr = 0, cmd_clr_wdt = 0, cmd_irq_en = 0, cmd_irq_dis = 0;
    logic cmd_freq_wr = 0;
    logic [2:0] freq_sel = 3'd0;
    logic tb_out, wdt_flag, irq_oe, irq_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_pre, m_div, m_cnt, m_wst, m_mode, m_freq;
    bit m_flag, m_irqen;

    always #5 clk = ~clk;

    tbwd_top u0 (
        .clk(clk), .rst_n(rst_n), .sys_on(sys_on), .src_tick(src_tick),
        .fast_src(fast_src), .cmd_tmr_en(cmd_tmr_en), .cmd_tmr_dis(cmd_tmr_dis),
        .cmd_wdt_en(cmd_wdt_en), .cmd_wdt_dis(cmd_wdt_dis),
        .cmd_clr_tmr(cmd_clr_tmr), .cmd_clr_wdt(cmd_clr_wdt),
        .cmd_irq_en(cmd_irq_en), .cmd_irq_dis(cmd_irq_dis),
        .cmd_freq_wr(cmd_freq_wr), .freq_sel(freq_sel),
        .tb_out(tb_out), .wdt_flag(wdt_flag), .irq_oe(irq_oe), .irq_val(irq_val)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pre = 0; m_div = 0; m_cnt = 0; m_wst = 0; m_mode = 0; m_freq = 7;
        m_flag = 0; m_irqen = 0;
    endtask

    task automatic model_step();
        bit en, base, dtick, adv, wrap;
        int mask;
        en   = sys_on && src_tick;
        base = en && (!fast_src || m_pre == 7);
        mask = (1 << (7 - m_freq)) - 1;
        dtick = base && ((m_div & mask) == mask);
        if (en && fast_src) m_pre = (m_pre + 1) % 8;
        if (base) m_div = (m_div + 1) % 128;
        adv  = dtick && (m_mode != 0) && !cmd_clr_wdt && !cmd_clr_tmr;
        wrap = adv && (m_cnt == 255);
        if (cmd_clr_wdt || cmd_irq_dis) m_flag = 0;
        else if (wrap && m_mode == 2 && m_wst == 3) m_flag = 1;
        if (cmd_clr_wdt) begin m_cnt = 0; m_wst = 0; end
        else if (cmd_clr_tmr) m_cnt = 0;
        else if (adv) begin
            m_cnt = (m_cnt + 1) % 256;
            if (wrap && m_mode == 2) m_wst = (m_wst + 1) % 4;
        end
        if (cmd_wdt_dis) m_mode = 0;
        else if (cmd_tmr_dis && m_mode == 1) m_mode = 0;
        else if (cmd_wdt_en) m_mode = 2;
        else if (cmd_tmr_en) m_mode = 1;
        if (cmd_freq_wr) m_freq = freq_sel;
        if (cmd_irq_dis) m_irqen = 0;
        else if (cmd_irq_en) m_irqen = 1;
    endtask

    task automatic compare();
        int etb;
        etb = (m_mode == 1) ? (m_cnt >> 7) & 1 : 0;
        check("R3/R5", "tb_out", tb_out, etb);
        check("R7", "wdt_flag", wdt_flag, m_flag);
        check("R9", "irq_oe", irq_oe, m_irqen);
        check("R9", "irq_val", irq_val, (m_mode == 1) ? etb : !m_flag);
    endtask

    task automatic clear_cmds();
        cmd_tmr_en = 0; cmd_tmr_dis = 0; cmd_wdt_en = 0; cmd_wdt_dis = 0;
        cmd_clr_tmr = 0; cmd_clr_wdt = 0; cmd_irq_en = 0; cmd_irq_dis = 0;
        cmd_freq_wr = 0;
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
            clear_cmds();
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "tb_out", tb_out, 0);
        check("R1", "wdt_flag", wdt_flag, 0);
        check("R1", "irq_oe", irq_oe, 0);
        check("R1", "irq_val", irq_val, 1);
        rst_n = 1'b1;
        sys_on = 1; src_tick = 1; fast_src = 0;

        // R3: fastest code, tick wave rises after 128 advances
        cmd_irq_en = 1; cmd_clr_tmr = 1; cmd_tmr_en = 1;
        cyc(1);
        cyc(127);
        check("R3", "tb_out before half period", tb_out, 0);
        cyc(1);
        check("R3", "tb_out at half period", tb_out, 1);
        check("R9", "irq_val follows tick", irq_val, 1);

        // R3: code 5 -> one advance per 4 base ticks
        cmd_freq_wr = 1; freq_sel = 3'd5; cmd_clr_tmr = 1;
        cyc(1);
        cyc(508);
        check("R3", "tb_out code5 early", tb_out, 0);
        cyc(4);
        check("R3", "tb_out code5 half period", tb_out, 1);

        // R2: prescaler on, code 7 -> 8 src ticks per advance
        cmd_freq_wr = 1; freq_sel = 3'd7; fast_src = 1; cmd_clr_tmr = 1;
        cyc(1);
        cyc(128 * 8 - 16);
        check("R2", "tb_out with prescaler early", tb_out, 0);
        cyc(16);
        check("R2", "tb_out with prescaler", tb_out, 1);

        // R7: watchdog trips on the 1024th advance
        fast_src = 0;
        cmd_clr_wdt = 1; cmd_wdt_en = 1;
        cyc(1);
        cyc(1023);
        check("R7", "flag one before trip", wdt_flag, 0);
        cyc(1);
        check("R7", "flag at trip", wdt_flag, 1);
        check("R9", "irq_val low on trip", irq_val, 0);
        check("R9", "irq_oe on trip", irq_oe, 1);

        // R4: stop_tick in GUARD ignored; R7 flag sticky
        cmd_tmr_dis = 1;
        cyc(50);
        check("R4", "still guard (irq_val inverted flag)", irq_val, 0);
        check("R7", "flag sticky", wdt_flag, 1);
        cmd_irq_dis = 1;
        cyc(1);
        check("R7", "flag cleared by irq_dis", wdt_flag, 0);
        check("R9", "irq_oe off", irq_oe, 0);

        // R8: freeze during power-down
        cmd_irq_en = 1; cmd_clr_wdt = 1;
        cyc(1);
        sys_on = 0;
        cyc(2000);
        check("R8", "no trip while frozen", wdt_flag, 0);
        sys_on = 1;
        cyc(1023);
        check("R8", "no trip one short after resume", wdt_flag, 0);
        cyc(1);
        check("R8", "trip after resume", wdt_flag, 1);

        // R6: clr_wdt clears flag and count
        cmd_clr_wdt = 1;
        cyc(1);
        check("R6", "flag after clr_wdt", wdt_flag, 0);

        // R4/R5: stop_all then hold in IDLE
        cmd_wdt_dis = 1; cmd_tmr_en = 1; cmd_clr_tmr = 1;
        cyc(1);
        check("R4", "stop_all wins -> idle tb_out", tb_out, 0);
        cyc(200);
        check("R5", "tb_out zero in idle", tb_out, 0);
        cmd_tmr_en = 1;
        cyc(1);
        check("R5", "counter held in idle", tb_out, 0);
        cyc(127);
        check("R5", "resume from held value early", tb_out, 0);
        cyc(1);
        check("R5", "resume from held value", tb_out, 1);

        // R4: start_guard beats start_tick
        cmd_wdt_en = 1; cmd_tmr_en = 1;
        cyc(1);
        check("R4", "guard wins over tick", tb_out, 0);

        // randomised phase, model compared every clock
        for (int k = 0; k < 6000; k++) begin
            src_tick    = ($urandom % 4) != 0;
            if (k % 700 == 0) fast_src = $urandom % 2;
            sys_on      = ($urandom % 16) != 0;
            cmd_tmr_en  = ($urandom % 64) == 0;
            cmd_tmr_dis = ($urandom % 64) == 0;
            cmd_wdt_en  = ($urandom % 64) == 0;
            cmd_wdt_dis = ($urandom % 128) == 0;
            cmd_clr_tmr = ($urandom % 128) == 0;
            cmd_clr_wdt = ($urandom % 128) == 0;
            cmd_irq_en  = ($urandom % 32) == 0;
            cmd_irq_dis = ($urandom % 128) == 0;
            cmd_freq_wr = ($urandom % 200) == 0;
            freq_sel    = 3'd4 + 3'($urandom % 4);
            cyc(1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule